// File: doc/BRIEF.md
# Sequential Radix-4 Signed Multiplier

This block multiplies a signed A_W-bit multiplicand by a signed B_W-bit multiplier (B_W even) and returns the signed (A_W+B_W)-bit product. It works through the multiplier two bits per clock. On each step it looks at a three-bit window: the current bit pair plus the upper bit of the pair before it. It turns that window into a signed digit in the range -2 to +2. The digit picks zero, the multiplicand, or twice the multiplicand. That multiple is added to or subtracted from a guarded accumulator, and then the accumulator and the remaining multiplier bits shift right arithmetically by two places. A product therefore takes B_W/2 add steps.

The handshake is simple. A one-cycle `start` in the idle state captures both operands. When the product is ready, `done` pulses for one cycle. The product stays on `product` until the next accepted `start`. Any `start` seen during a multiplication, or in the cycle that `done` is high, is dropped.

Top module: `booth_mult`

## Requirements
- R1: While `rstN` is low, `done` is 0 and `product` is all zeros.
- R2: In the cycle `done` is high, `product` equals the two's-complement product of the `multA` and `multB` values that were captured when `start` was accepted.
- R3: `start` is accepted only in the idle state, on a rising edge. `done` is then high during the cycle after the (B_W/2+1)-th rising edge, counting the accepting edge as the first, and it stays high for exactly one cycle.
- R4: `start` at any rising edge while a multiplication runs, or while `done` is high, is ignored. The running result is unchanged and no extra `done` follows.
- R5: Each step recodes the window {bit k+1, bit k, bit k-1} as follows: 000 and 111 add 0; 001 and 010 add A; 011 adds 2A; 100 subtracts 2A; 101 and 110 subtract A. A subtraction is done as an addition of the complemented multiple with a carry-in of 1.
- R6: The bit below multiplier bit 0 is taken as 0 for the first window. For example, a multiplier of 1 gives exactly A.
- R7: Most-negative times most-negative, -2^(A_W-1) × -2^(B_W-1), gives +2^(A_W+B_W-2) with no overflow.
- R8: A multiplier of all ones (-1) gives -A, including for the most negative A, where the result is +2^(A_W-1).
- R9: A zero multiplicand or a zero multiplier gives a zero product.
- R10: After `done`, `product` holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiplication, honoured in idle only |
| multA | input | A_W | Signed multiplicand |
| multB | input | B_W | Signed multiplier, B_W even |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | A_W+B_W | Signed product, held after done |

## Verification
Every multiplier value is swept against a positive, a negative, a most-negative and a minus-one multiplicand. This reaches every window code in every digit position, so a wrong entry in the recoding table, a lost carry-in on subtraction, or a bad implicit low bit each give a wrong product. Directed cases cover the corners where the guard bits matter: most-negative times most-negative, an all-ones multiplier, and zero operands. A random set of operand pairs is run against a signed reference product. A separate run holds `start` high with different operands for the whole multiplication and through the `done` cycle. That run shows that the first result survives and that exactly one `done` appears. Latency is measured for every operation against the stated edge count.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // perform one radix-4 add/shift step
  } boothCtrl_t;

  // Recoded signed digit: magnitude 0, 1 or 2 and a sign
  typedef struct packed {
    logic zero;   // digit is 0
    logic dbl;    // magnitude is 2
    logic neg;    // digit is negative
  } boothDigit_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mult_pkg::*;
(
  input  logic [2:0]  window,   // {b[k+1], b[k], b[k-1]}
  output boothDigit_t digit
);

  always_comb begin
    digit.zero = (window == 3'b000) || (window == 3'b111);
    digit.dbl  = (window == 3'b011) || (window == 3'b100);
    digit.neg  = window[2] && !(window[1] && window[0]);
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_mult_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output boothCtrl_t ctrlBus,
  output logic       done
);

  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          if (stepCnt == LAST) state <= ST_FIN;
          else                 stepCnt <= stepCnt + 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlBus.load = (state == ST_IDLE) && start;
    ctrlBus.step = (state == ST_RUN);
    done         = (state == ST_FIN);
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_mult_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  boothCtrl_t         ctrlBus,
  input  logic [A_W-1:0]     multA,
  input  logic [B_W-1:0]     multB,
  output logic [A_W+B_W-1:0] product
);

  // two guard bits keep +/-2A of the most negative A in range
  localparam int HI_W  = A_W + 2;
  localparam int ALL_W = HI_W + B_W;

  logic [HI_W-1:0] hiAcc;
  logic [B_W-1:0]  loReg;
  logic            prevBit;
  logic [A_W-1:0]  aReg;

  boothDigit_t       digit;
  logic [HI_W-1:0]   aExt;
  logic [HI_W-1:0]   multiple;
  logic [HI_W-1:0]   operand;
  logic [HI_W-1:0]   sum;
  logic signed [ALL_W-1:0] shifted;

  booth_recoder u_recoder (
    .window ({loReg[1], loReg[0], prevBit}),
    .digit  (digit)
  );

  always_comb begin
    aExt     = {{2{aReg[A_W-1]}}, aReg};
    if (digit.zero)     multiple = '0;
    else if (digit.dbl) multiple = {aExt[HI_W-2:0], 1'b0};
    else                multiple = aExt;
    // subtraction = add of complement with carry-in
    operand  = digit.neg ? ~multiple : multiple;
    sum      = hiAcc + operand + {{(HI_W-1){1'b0}}, digit.neg};
    shifted  = $signed({sum, loReg}) >>> 2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiAcc   <= '0;
      loReg   <= '0;
      prevBit <= 1'b0;
      aReg    <= '0;
    end else if (ctrlBus.load) begin
      hiAcc   <= '0;
      loReg   <= multB;
      prevBit <= 1'b0;
      aReg    <= multA;
    end else if (ctrlBus.step) begin
      hiAcc   <= shifted[ALL_W-1:B_W];
      loReg   <= shifted[B_W-1:0];
      prevBit <= loReg[1];
    end
  end

  assign product = {hiAcc[A_W-1:0], loReg};

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_mult_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [A_W-1:0]     multA,
  input  logic [B_W-1:0]     multB,
  output logic               done,
  output logic [A_W+B_W-1:0] product
);

  localparam int STEPS = B_W / 2;

  boothCtrl_t ctrlBus;

  booth_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctrlBus (ctrlBus),
    .done    (done)
  );

  booth_datapath #(.A_W(A_W), .B_W(B_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlBus (ctrlBus),
    .multA   (multA),
    .multB   (multB),
    .product (product)
  );

endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk
  import booth_mult_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [A_W-1:0]     multA,
  input logic [B_W-1:0]     multB,
  input logic               done,
  input logic [A_W+B_W-1:0] product,
  input boothCtrl_t         ctrlBus
);

  localparam int PROD_W = A_W + B_W;
  localparam int STEPS  = B_W / 2;
  localparam int SC_W   = $clog2(STEPS + 1) + 1;

  logic signed [A_W-1:0]    capA;
  logic signed [B_W-1:0]    capB;
  logic signed [PROD_W-1:0] refProd;
  logic [SC_W-1:0]          seenSteps;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capA      <= '0;
      capB      <= '0;
      seenSteps <= '0;
    end else if (ctrlBus.load) begin
      capA      <= multA;
      capB      <= multB;
      seenSteps <= '0;
    end else if (ctrlBus.step) begin
      seenSteps <= seenSteps + 1'b1;
    end
  end

  assign refProd = capA * capB;

  // R2
  result_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> product == refProd);

  // R3
  step_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> seenSteps == SC_W'(STEPS));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.step || done) |-> !ctrlBus.load);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBus.load && !ctrlBus.step) |=> $stable(product));

endmodule

bind booth_mult booth_mult_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .multA   (multA),
  .multB   (multB),
  .done    (done),
  .product (product),
  .ctrlBus (ctrlBus)
);

// File: tb/tb_booth_mult.sv
`timescale 1ns/1ps
module tb_booth_mult;

  localparam int A_W = 8;
  localparam int B_W = 8;
  localparam int PW  = A_W + B_W;
  localparam int S   = B_W / 2;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  start = 1'b0;
  logic signed [A_W-1:0] aIn = '0;
  logic signed [B_W-1:0] bIn = '0;
  logic                  done;
  logic [PW-1:0]         product;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  int nIssued = 0;
  int nDone   = 0;
  bit prevDone = 1'b0;

  logic [PW-1:0] expQ[$];
  int            issueQ[$];
  string         tagQ[$];

  booth_mult #(.A_W(A_W), .B_W(B_W)) dut (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .multA   (aIn),
    .multB   (bIn),
    .done    (done),
    .product (product)
  );

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        nDone++;
        check(!prevDone, "R3 done longer than one cycle", 1, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected done", 1, 0);
        end else begin
          logic [PW-1:0] e;
          int            iss;
          string         tg;
          e   = expQ.pop_front();
          iss = issueQ.pop_front();
          tg  = tagQ.pop_front();
          check(product == e, tg, longint'(product), longint'(e));
          check(cyc == iss + S, "R3 latency", cyc - iss, S);
        end
      end
      prevDone = done;
    end
  end

  // driver: one multiplication, then a hold check
  task automatic issue(input logic signed [A_W-1:0] a,
                       input logic signed [B_W-1:0] b,
                       input string tag);
    logic [PW-1:0] e;
    e = PW'(longint'(a) * longint'(b));
    @(negedge clk);
    aIn = a; bIn = b; start = 1'b1;
    expQ.push_back(e);
    issueQ.push_back(cyc + 1);
    tagQ.push_back(tag);
    nIssued++;
    @(negedge clk);
    start = 1'b0;
    repeat (S + 2) @(negedge clk);
    check(product == e, "R10 product held after done",
          longint'(product), longint'(e));
  endtask

  // start kept high with other operands through run and done cycle
  task automatic issueBusy(input logic signed [A_W-1:0] a,
                           input logic signed [B_W-1:0] b,
                           input logic signed [A_W-1:0] ga,
                           input logic signed [B_W-1:0] gb);
    logic [PW-1:0] e;
    int            doneBefore;
    e = PW'(longint'(a) * longint'(b));
    doneBefore = nDone;
    @(negedge clk);
    aIn = a; bIn = b; start = 1'b1;
    expQ.push_back(e);
    issueQ.push_back(cyc + 1);
    tagQ.push_back("R4 result with start held busy");
    nIssued++;
    for (int i = 0; i < S + 1; i++) begin
      @(negedge clk);
      aIn = ga ^ A_W'(i); bIn = gb ^ B_W'(i);
    end
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(product == e, "R4 product after ignored starts",
          longint'(product), longint'(e));
    check(nDone == doneBefore + 1, "R4 done count", nDone - doneBefore, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(product == '0, "R1 product in reset", longint'(product), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7 corner
    issue(-128, -128, "R7 most negative squared");
    issue(-128, 127, "R7 min times max");
    issue(127, -128, "R7 max times min");
    issue(127, 127, "R2 max squared");
    // R8 all ones multiplier
    issue(-128, -1, "R8 min times minus one");
    issue(55, -1, "R8 positive times minus one");
    issue(-1, -1, "R8 minus one squared");
    // R9 zero operands
    issue(0, 93, "R9 zero multiplicand");
    issue(-77, 0, "R9 zero multiplier");
    issue(0, -128, "R9 zero times min");
    // R6 implicit low bit
    issue(-101, 1, "R6 multiplier one");
    issue(113, 2, "R6 multiplier two");

    // R5 sweep every multiplier code for several multiplicands
    for (int av = 0; av < 4; av++) begin
      logic signed [A_W-1:0] aSel;
      case (av)
        0: aSel = 8'sd37;
        1: aSel = -8'sd90;
        2: aSel = -8'sd128;
        default: aSel = -8'sd1;
      endcase
      for (int bv = 0; bv < (1 << B_W); bv++)
        issue(aSel, B_W'(bv), "R5 recoding sweep");
    end

    // R2 random operands
    for (int k = 0; k < 200; k++)
      issue(A_W'($urandom), B_W'($urandom), "R2 random product");

    // R4 start ignored while busy
    issueBusy(-46, 91, 17, -3);
    issueBusy(-128, -128, 5, 5);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R4 all results retired", expQ.size(), 0);
    check(nDone == nIssued, "R3 done per accepted start", nDone, nIssued);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule